// File: doc/BRIEF.md
# Offset Min-Sum Check Node Unit

This block is the check-node stage of a layered LDPC decoder working on Z check rows in parallel; one instance covers one row lane. During a layer it receives a variable-to-check message for each non-zero block column. Each message is 8-bit two's complement. The block reduces the layer to a small summary: the smallest and the next-smallest magnitude, the column that held the smallest, and the parity of all the sign bits. It also keeps the sign of each column.

When the last message of a layer arrives, the summary is copied into a published bank. Each of three consumer ports keeps its own copy of the column signs. The three consumers are the LLR update path, the store for the next iteration and the gain path. Each can ask for any column in any order and gets that column's check-to-variable message one cycle later. The magnitude is the offset min-sum value, clamped to a 6-bit signed range. The next layer can build up in the working registers while the published bank is being read.

Top module: `osms_cnu`

## Requirements
- R1: The sign of an input message is its bit 7. Its magnitude is its two's-complement absolute value, so 8'h80 has magnitude 128.
- R2: Over a layer the unit finds the smallest magnitude, the second-smallest magnitude and the column of the smallest. A beat with `in_first` high ignores all earlier beats. For each requested column, the selected magnitude is the smallest magnitude among the layer's other columns. If a layer has a single column, that column's selected magnitude is 255.
- R3: If two magnitudes tie for the minimum, the column seen first keeps the minimum index, and the second minimum takes the equal value.
- R4: The column at the minimum index gets the second minimum. Every other column gets the minimum.
- R5: The output magnitude is the selected magnitude minus OFFSET (default 2), floored at 0.
- R6: The output sign is the XOR of the layer's sign parity and the requested column's own sign. A zero magnitude is output as 0.
- R7: The output is 6-bit two's complement. Magnitudes above 31 are clamped to 31, so the value -32 never appears.
- R8: The three ports are independent. They may request different columns in the same cycle, and each answers for its own request.
- R9: A port's valid output is high exactly one cycle after its request is high, and low otherwise.
- R10: The published summary changes only on the edge that accepts a beat with `in_last` high. Reads made while a later layer is still building up return the earlier layer.
- R11: After reset no port is valid, and a read of any column returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Message beat present |
| in_first | input | 1 | Beat is the first of a layer |
| in_last | input | 1 | Beat is the last of a layer |
| in_col | input | 3 | Block column of the beat |
| in_msg | input | 8 | Variable-to-check message, two's complement |
| upd_req | input | 1 | LLR-update port request |
| upd_col | input | 3 | LLR-update port column |
| upd_vld | output | 1 | LLR-update port result valid |
| upd_msg | output | 6 | LLR-update port check-to-variable message |
| nxt_req | input | 1 | Next-iteration port request |
| nxt_col | input | 3 | Next-iteration port column |
| nxt_vld | output | 1 | Next-iteration port result valid |
| nxt_msg | output | 6 | Next-iteration port message |
| gn_req | input | 1 | Gain port request |
| gn_col | input | 3 | Gain port column |
| gn_vld | output | 1 | Gain port result valid |
| gn_msg | output | 6 | Gain port message |

## Verification
Five four-column layers are each read back on all three ports at once, with every port using a different column order.
- A layer with clear, distinct minima separates the minimum from the second minimum.
- A layer whose two smallest magnitudes are equal tests the tie rule.
- A layer of small magnitudes tests the floor at zero.
- A layer holding -128, 127 and other large values tests the clamp.
- A layer of alternating signs tests the parity.

Directed cases cover:
- reads right after reset;
- a single-column layer;
- reads made while a second layer is only partly loaded, which tell the published bank apart from the working registers.

// File: rtl/cnu_pkg.sv
// Package: shared constants for the check node unit.
// Assumes: three consumers, numbered by the enum below.
package cnu_pkg;
    localparam int NUM_PORTS = 3;

    typedef enum logic [1:0] {
        PORT_UPD  = 2'd0,
        PORT_NXT  = 2'd1,
        PORT_GAIN = 2'd2
    } port_id_e;
endpackage

// File: rtl/cnu_accum.sv
// Module: cnu_accum
// Folds a stream of two's-complement messages into min1, min2, the index of
// min1, the sign parity and a per-column sign vector. On the last beat of a
// layer the folded result is published, so the next layer can build up.
// Assumes: in_first marks the first beat, column indices are below COLS.
module cnu_accum #(
    parameter int IN_W  = 8,
    parameter int COLS  = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    input  logic [IDX_W-1:0] in_col,
    input  logic [IN_W-1:0]  in_msg,
    output logic [IN_W-1:0]  pub_min1,
    output logic [IN_W-1:0]  pub_min2,
    output logic [IDX_W-1:0] pub_idx,
    output logic             pub_par,
    output logic             pub_stb,
    output logic [COLS-1:0]  nxt_sgn
);
    localparam logic [IN_W-1:0] MAXV = '1;

    logic [IN_W-1:0]  w_min1, w_min2, b_min1, b_min2, n_min1, n_min2, mag;
    logic [IDX_W-1:0] w_idx, b_idx, n_idx;
    logic             w_par, b_par, n_par, sgn;
    logic [COLS-1:0]  w_sgn, b_sgn;

    // Split the beat into sign and magnitude.
    always_comb begin
        sgn = in_msg[IN_W-1];
        mag = sgn ? (IN_W'(0) - in_msg) : in_msg;
    end

    // Pick the fold base (fresh on a first beat) and fold in the new beat.
    always_comb begin
        b_min1 = in_first ? MAXV : w_min1;
        b_min2 = in_first ? MAXV : w_min2;
        b_idx  = in_first ? '0   : w_idx;
        b_par  = in_first ? 1'b0 : w_par;
        b_sgn  = in_first ? '0   : w_sgn;
        n_min1 = b_min1;
        n_min2 = b_min2;
        n_idx  = b_idx;
        if (mag < b_min1) begin
            n_min1 = mag;
            n_min2 = b_min1;
            n_idx  = in_col;
        end else if (mag < b_min2) begin
            n_min2 = mag;
        end
        n_par   = b_par ^ sgn;
        nxt_sgn = b_sgn;
        nxt_sgn[in_col] = sgn;
    end

    assign pub_stb = in_valid & in_last;

    // Working registers: updated on every accepted beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_min1 <= MAXV;
            w_min2 <= MAXV;
            w_idx  <= '0;
            w_par  <= 1'b0;
            w_sgn  <= '0;
        end else if (in_valid) begin
            w_min1 <= n_min1;
            w_min2 <= n_min2;
            w_idx  <= n_idx;
            w_par  <= n_par;
            w_sgn  <= nxt_sgn;
        end
    end

    // Published bank: loaded only by the closing beat of a layer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pub_min1 <= '0;
            pub_min2 <= '0;
            pub_idx  <= '0;
            pub_par  <= 1'b0;
        end else if (pub_stb) begin
            pub_min1 <= n_min1;
            pub_min2 <= n_min2;
            pub_idx  <= n_idx;
            pub_par  <= n_par;
        end
    end

    AST_MIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        pub_min1 <= pub_min2); // R2
    AST_FIRST_TAKES_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first) |=> (w_idx == $past(in_col))); // R2
    AST_TIE_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_first && mag == w_min1) |=> (w_idx == $past(w_idx))); // R3
    AST_PUB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pub_stb |=> ($stable(pub_min1) && $stable(pub_idx))); // R10
endmodule

// File: rtl/cnu_port.sv
// Module: cnu_port
// One read port. It keeps its own copy of the column signs and turns the
// published summary into an offset min-sum message, clamped to OUT_W bits,
// one cycle after a request.
// Assumes: the summary inputs stay stable except on pub_stb.
module cnu_port #(
    parameter int IN_W   = 8,
    parameter int OUT_W  = 6,
    parameter int COLS   = 8,
    parameter int IDX_W  = 3,
    parameter int OFFSET = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  pub_min1,
    input  logic [IN_W-1:0]  pub_min2,
    input  logic [IDX_W-1:0] pub_idx,
    input  logic             pub_par,
    input  logic             pub_stb,
    input  logic [COLS-1:0]  nxt_sgn,
    input  logic             req,
    input  logic [IDX_W-1:0] col,
    output logic             vld,
    output logic [OUT_W-1:0] msg
);
    localparam int OMAX = (1 << (OUT_W - 1)) - 1;

    logic [COLS-1:0]  sgn_store;
    logic [IN_W-1:0]  sel, red;
    logic [OUT_W-1:0] mag_o, val;
    logic             s;

    // Build the message for the requested column.
    always_comb begin
        sel   = (col == pub_idx) ? pub_min2 : pub_min1;
        red   = (sel > IN_W'(OFFSET)) ? (sel - IN_W'(OFFSET)) : '0;
        mag_o = (red > IN_W'(OMAX)) ? OUT_W'(OMAX) : red[OUT_W-1:0];
        s     = pub_par ^ sgn_store[col];
        val   = s ? (OUT_W'(0) - mag_o) : mag_o;
    end

    // Private sign store, refreshed when a layer is published.
    always_ff @(posedge clk) begin
        if (!rst_n)       sgn_store <= '0;
        else if (pub_stb) sgn_store <= nxt_sgn;
    end

    // Registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= 1'b0;
            msg <= '0;
        end else begin
            vld <= req;
            if (req) msg <= val;
        end
    end

    AST_REQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> vld); // R9
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !vld); // R9
    AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        vld |-> (msg != {1'b1, {(OUT_W-1){1'b0}}})); // R7
endmodule

// File: rtl/osms_cnu.sv
// Module: osms_cnu (top)
// Offset min-sum check node unit: one accumulator feeding three independent
// read ports, each with its own sign store.
// Assumes: one beat per cycle at most, a layer is framed by in_first/in_last.
module osms_cnu #(
    parameter int IN_W   = 8,
    parameter int OUT_W  = 6,
    parameter int COLS   = 8,
    parameter int OFFSET = 2,
    localparam int IDX_W = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_first,
    input  logic             in_last,
    input  logic [IDX_W-1:0] in_col,
    input  logic [IN_W-1:0]  in_msg,
    input  logic             upd_req,
    input  logic [IDX_W-1:0] upd_col,
    output logic             upd_vld,
    output logic [OUT_W-1:0] upd_msg,
    input  logic             nxt_req,
    input  logic [IDX_W-1:0] nxt_col,
    output logic             nxt_vld,
    output logic [OUT_W-1:0] nxt_msg,
    input  logic             gn_req,
    input  logic [IDX_W-1:0] gn_col,
    output logic             gn_vld,
    output logic [OUT_W-1:0] gn_msg
);
    import cnu_pkg::*;

    logic [IN_W-1:0]  pub_min1, pub_min2;
    logic [IDX_W-1:0] pub_idx;
    logic             pub_par, pub_stb;
    logic [COLS-1:0]  nxt_sgn;

    logic             p_req [NUM_PORTS];
    logic [IDX_W-1:0] p_col [NUM_PORTS];
    logic             p_vld [NUM_PORTS];
    logic [OUT_W-1:0] p_msg [NUM_PORTS];

    // Map the named consumer ports onto the port arrays.
    always_comb begin
        p_req[PORT_UPD]  = upd_req;
        p_col[PORT_UPD]  = upd_col;
        p_req[PORT_NXT]  = nxt_req;
        p_col[PORT_NXT]  = nxt_col;
        p_req[PORT_GAIN] = gn_req;
        p_col[PORT_GAIN] = gn_col;
        upd_vld = p_vld[PORT_UPD];
        upd_msg = p_msg[PORT_UPD];
        nxt_vld = p_vld[PORT_NXT];
        nxt_msg = p_msg[PORT_NXT];
        gn_vld  = p_vld[PORT_GAIN];
        gn_msg  = p_msg[PORT_GAIN];
    end

    cnu_accum #(.IN_W(IN_W), .COLS(COLS), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_col(in_col), .in_msg(in_msg),
        .pub_min1(pub_min1), .pub_min2(pub_min2), .pub_idx(pub_idx),
        .pub_par(pub_par), .pub_stb(pub_stb), .nxt_sgn(nxt_sgn)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        cnu_port #(.IN_W(IN_W), .OUT_W(OUT_W), .COLS(COLS), .IDX_W(IDX_W),
                   .OFFSET(OFFSET)) u_port (
            .clk(clk), .rst_n(rst_n), .pub_min1(pub_min1), .pub_min2(pub_min2),
            .pub_idx(pub_idx), .pub_par(pub_par), .pub_stb(pub_stb),
            .nxt_sgn(nxt_sgn), .req(p_req[g]), .col(p_col[g]),
            .vld(p_vld[g]), .msg(p_msg[g])
        );
    end
endmodule

// File: tb/sim_osms_cnu.sv
// Bench for osms_cnu: a table of layers walked by one loop, then directed
// cases for reset, a single-column layer and the double-buffered bank.
module sim_osms_cnu;
    localparam int OFF = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 0, in_first = 0, in_last = 0;
    logic [2:0] in_col = '0;
    logic [7:0] in_msg = '0;
    logic       upd_req = 0, nxt_req = 0, gn_req = 0;
    logic [2:0] upd_col = '0, nxt_col = '0, gn_col = '0;
    logic       upd_vld, nxt_vld, gn_vld;
    logic [5:0] upd_msg, nxt_msg, gn_msg;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [7:0] lm [8];
    logic [7:0] lmask;

    // Column 0 sits in bits 31:24.
    localparam logic [31:0] LAYERS [5] = '{
        32'h0AFD0714,   // distinct minima
        32'hFBFB28F7,   // tie on magnitude 5
        32'h00010264,   // floor at zero
        32'h807F9C5A,   // clamp
        32'h03FD03FD    // alternating signs
    };

    always #2.5 clk = ~clk;

    osms_cnu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_col(in_col), .in_msg(in_msg),
        .upd_req(upd_req), .upd_col(upd_col), .upd_vld(upd_vld), .upd_msg(upd_msg),
        .nxt_req(nxt_req), .nxt_col(nxt_col), .nxt_vld(nxt_vld), .nxt_msg(nxt_msg),
        .gn_req(gn_req), .gn_col(gn_col), .gn_vld(gn_vld), .gn_msg(gn_msg)
    );

    // Expected message: minimum over the other columns, sign parity of the others.
    function automatic logic [5:0] expect_msg(input int c);
        int m = 255;
        bit s = 0;
        for (int k = 0; k < 8; k++) begin
            if (lmask[k] && k != c) begin
                int mg = lm[k][7] ? 256 - int'(lm[k]) : int'(lm[k]);
                if (mg < m) m = mg;
                s ^= lm[k][7];
            end
        end
        m = (m > OFF) ? m - OFF : 0;
        if (m > 31) m = 31;
        return s ? 6'(-m) : 6'(m);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Send n beats from lm, in column order, as one layer.
    task automatic feed(input int n, input bit close);
        int sent = 0;
        for (int k = 0; k < 8; k++) begin
            if (lmask[k]) begin
                @(negedge clk);
                in_valid = 1; in_col = 3'(k); in_msg = lm[k];
                in_first = (sent == 0); in_last = close && (sent == n - 1);
                sent++;
            end
        end
        @(negedge clk);
        in_valid = 0; in_first = 0; in_last = 0;
    endtask

    // Request three columns at once and check every port (R8, R9).
    task automatic read3(input int cu, input int cn, input int cg, input string tag);
        upd_req = 1; upd_col = 3'(cu);
        nxt_req = 1; nxt_col = 3'(cn);
        gn_req  = 1; gn_col  = 3'(cg);
        @(negedge clk);
        upd_req = 0; nxt_req = 0; gn_req = 0;
        chk(upd_vld && nxt_vld && gn_vld, {tag, " R9 valid"}, int'(upd_vld), 1);
        chk(upd_msg == expect_msg(cu), {tag, " upd R8"}, int'($signed(upd_msg)), int'($signed(expect_msg(cu))));
        chk(nxt_msg == expect_msg(cn), {tag, " nxt R8"}, int'($signed(nxt_msg)), int'($signed(expect_msg(cn))));
        chk(gn_msg == expect_msg(cg),  {tag, " gn R8"},  int'($signed(gn_msg)),  int'($signed(expect_msg(cg))));
        @(negedge clk);
        chk(!upd_vld && !nxt_vld && !gn_vld, {tag, " R9 idle"}, int'(upd_vld), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11: nothing valid, reads return 0.
        chk(!upd_vld && !nxt_vld && !gn_vld, "R11 valid low", int'(upd_vld), 0);
        upd_req = 1; upd_col = 3'd4; nxt_req = 1; nxt_col = 3'd0; gn_req = 1; gn_col = 3'd7;
        @(negedge clk);
        upd_req = 0; nxt_req = 0; gn_req = 0;
        chk(upd_msg == 0 && nxt_msg == 0 && gn_msg == 0, "R11 zero read", int'(upd_msg), 0);

        // Table walk: R1..R7 through the three ports in different orders.
        for (int l = 0; l < 5; l++) begin
            lmask = 8'h0F;
            for (int k = 0; k < 8; k++) lm[k] = 8'h00;
            for (int k = 0; k < 4; k++) lm[k] = LAYERS[l][31 - 8*k -: 8];
            feed(4, 1);
            for (int b = 0; b < 4; b++) begin
                int ord2 [4] = '{2, 0, 3, 1};
                read3(b, 3 - b, ord2[b], $sformatf("layer%0d R1 R2 R3 R4 R5 R6 R7", l));
            end
        end

        // R2/R7: a single column gets 255, clamped to 31.
        lmask = 8'h20;
        for (int k = 0; k < 8; k++) lm[k] = 8'h00;
        lm[5] = 8'h91;
        feed(1, 1);
        read3(5, 5, 5, "single R2 R7");
        chk(upd_msg == 6'd31, "single R7 value", int'(upd_msg), 31);

        // R10: load layer A, then part of layer B; reads still show A.
        lmask = 8'h0F;
        lm[0] = 8'h0A; lm[1] = 8'hF0; lm[2] = 8'h06; lm[3] = 8'h09; lm[5] = 8'h00;
        feed(4, 1);
        lm[0] = 8'h01; lm[1] = 8'h01; lm[2] = 8'h01; lm[3] = 8'h7F;
        feed(4, 0);
        lm[0] = 8'h0A; lm[1] = 8'hF0; lm[2] = 8'h06; lm[3] = 8'h09;
        read3(2, 1, 0, "open layer R10");
        lm[0] = 8'h01; lm[1] = 8'h01; lm[2] = 8'h01; lm[3] = 8'h7F;
        feed(4, 1);
        read3(3, 0, 1, "closed layer R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule